// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen Shadow

This block keeps calendar time in packed BCD: hundredths of seconds, seconds, minutes, hours, day of week, date, month and two-digit year. A 100 Hz tick enable moves an internal running copy of the time forward. Software never reads the running copy directly. It sees a second, visible copy through a byte-wide register bus with a single-cycle write strobe and a combinational read.

While transfer is enabled, the visible copy follows the running copy. When software clears transfer enable, the visible copy holds still and can be read or written as one coherent snapshot, and the running copy keeps counting. Fields written during the freeze are loaded into the running copy when transfer is enabled again. The hours field can be shown in 24-hour form or in 12-hour form with a PM flag. The month register also holds an active-low oscillator enable and an active-low enable for a square-wave output.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset the registers read as follows: hundredths, seconds, minutes and hours 0x00 (24-hour form), day of week 0x01, date 0x01, month 0x41 (oscillator running, square wave off), year 0x00, command 0x80 (transfer enabled). The square-wave output enable is 0.
- R2: Each tick_i cycle with the oscillator running advances hundredths by one, from 00 to 99. A step from 99 gives 00 and carries into seconds. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. A tens digit carries when its ones digit passes 9.
- R3: While transfer enable (command offset 0xB, bit 7) is 1, the visible registers equal the running time from the clock edge that updates the running copy.
- R4: Writing 0x00 to offset 0xB freezes the visible registers while the running copy keeps counting. Writing 0x80 afterwards makes the visible registers show the running time from the next edge.
- R5: A time register written while frozen reads back the written value. On re-enable, each written field is loaded into the running copy, and counting continues from the written values, including a written hundredths value. Fields that were not written keep their running values.
- R6: In 24-hour form (hours bit 6 = 0), hours step 09 to 10, 19 to 20, and 23 to 00. The step from 23 to 00 advances the date and the day of week.
- R7: In 12-hour form (hours bit 6 = 1, bit 5 = PM), the hour values run from 01 to 12. The step from 11 to 12 toggles PM, so 11 AM (0x51) becomes 12 PM (0x72). The step from 12 to 01 keeps PM. Only the step from 11 PM (0x71) to 12 AM (0x52) advances the date.
- R8: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other months. In February it wraps after 28, or after 29 when the BCD year is a multiple of 4 (00 included). The month wraps from 12 to 01 and then advances the year, and the year wraps from 99 to 00.
- R9: Day of week counts 1 to 7 and wraps from 7 to 1.
- R10: Month bit 7 = 1 stops all time advance. Month bit 6 = 0 sets sqw_oe_o to 1 and makes sqw_o follow sq_ref_i. Month bit 6 = 1 sets both outputs to 0. Both bits take effect one edge after the write, whatever the transfer state.
- R11: Bits a field does not use read 0, whatever was written. This covers seconds, minutes and hours bit 7, day of week bits 7..3, date bits 7..6, month bit 5 and command bits 6..0. Offsets 3, 5, 7 and 0xC to 0xF always read 0x00.
- R12: With transfer enabled, a write to a time register updates the visible and running copies at the write edge, and the next tick counts on from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 100 Hz advance enable, one cycle wide |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, from the visible copy |
| sq_ref_i | input | 1 | 1024 Hz reference level |
| sqw_o | output | 1 | Square-wave output |
| sqw_oe_o | output | 1 | Square-wave output enable (0 = high impedance) |

## Verification
A tick or a write is captured at one rising edge, and its effect shows in the registers after that same edge. Reads are combinational from the visible copy, so a result can be read half a cycle after the capturing edge. The bench drives strobes on falling edges for exactly one cycle, then sets the read address on the next falling edge and samples a few nanoseconds later, well away from any rising edge. Each rollover vector presets a time while frozen, re-enables transfer, applies exactly one tick and then reads every field, so each expected value is the result of a single step.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int unsigned NUM_FLD = 8;

  localparam int unsigned OFS_HUND = 0;
  localparam int unsigned OFS_SEC  = 1;
  localparam int unsigned OFS_MIN  = 2;
  localparam int unsigned OFS_HOUR = 4;
  localparam int unsigned OFS_DOW  = 6;
  localparam int unsigned OFS_DATE = 8;
  localparam int unsigned OFS_MON  = 9;
  localparam int unsigned OFS_YEAR = 10;
  localparam int unsigned OFS_CMD  = 11;

  localparam int unsigned FLD_HUND = 0;
  localparam int unsigned FLD_SEC  = 1;
  localparam int unsigned FLD_MIN  = 2;
  localparam int unsigned FLD_HOUR = 3;
  localparam int unsigned FLD_DOW  = 4;
  localparam int unsigned FLD_DATE = 5;
  localparam int unsigned FLD_MON  = 6;
  localparam int unsigned FLD_YEAR = 7;

  typedef struct packed {
    logic [7:0] hund;
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] month;
    logic [7:0] year;
  } cal_time_t;

  localparam cal_time_t CAL_RST = '{hund: 8'h00, sec: 7'h00, min: 7'h00,
                                    hour: 7'h00, dow: 3'd1, date: 6'h01,
                                    month: 5'h01, year: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // BCD year divisible by 4: even tens with ones 0/4/8, odd tens with ones 2/6
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
  endfunction

  function automatic logic [5:0] last_date(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import bcd_cal_pkg::*;
(
  input  cal_time_t cur_i,
  output cal_time_t nxt_o
);

  logic [7:0] inc_hund, inc_sec, inc_min, inc_h12, inc_h24, inc_date, inc_mon, inc_year;
  logic [7:0] hv12, hv24;
  logic       c_sec, c_min, c_hr, c_day, c_mon, c_yr;

  assign hv12     = {3'b000, cur_i.hour[4:0]};
  assign hv24     = {2'b00, cur_i.hour[5:0]};
  assign inc_hund = bcd_inc(cur_i.hund);
  assign inc_sec  = bcd_inc({1'b0, cur_i.sec});
  assign inc_min  = bcd_inc({1'b0, cur_i.min});
  assign inc_h12  = bcd_inc(hv12);
  assign inc_h24  = bcd_inc(hv24);
  assign inc_date = bcd_inc({2'b00, cur_i.date});
  assign inc_mon  = bcd_inc({3'b000, cur_i.month});
  assign inc_year = bcd_inc(cur_i.year);

  assign c_sec = (cur_i.hund == 8'h99);
  assign c_min = c_sec && (cur_i.sec == 7'h59);
  assign c_hr  = c_min && (cur_i.min == 7'h59);

  always_comb begin
    nxt_o = cur_i;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    nxt_o.hund = c_sec ? 8'h00 : inc_hund;
    if (c_sec) nxt_o.sec = c_min ? 7'h00 : inc_sec[6:0];
    if (c_min) nxt_o.min = c_hr ? 7'h00 : inc_min[6:0];
    if (c_hr) begin
      if (cur_i.hour[6]) begin
        if (hv12 == 8'h12) begin
          nxt_o.hour = {1'b1, cur_i.hour[5], 5'h01};
        end else if (hv12 == 8'h11) begin
          nxt_o.hour = {1'b1, ~cur_i.hour[5], 5'h12};
          c_day      = cur_i.hour[5];
        end else begin
          nxt_o.hour = {1'b1, cur_i.hour[5], inc_h12[4:0]};
        end
      end else if (hv24 == 8'h23) begin
        nxt_o.hour = 7'h00;
        c_day      = 1'b1;
      end else begin
        nxt_o.hour = {1'b0, inc_h24[5:0]};
      end
    end
    if (c_day) begin
      nxt_o.dow = (cur_i.dow == 3'd7) ? 3'd1 : cur_i.dow + 3'd1;
      if (cur_i.date == last_date(cur_i.month, cur_i.year)) begin
        nxt_o.date = 6'h01;
        c_mon      = 1'b1;
      end else begin
        nxt_o.date = inc_date[5:0];
      end
    end
    if (c_mon) begin
      if (cur_i.month == 5'h12) begin
        nxt_o.month = 5'h01;
        c_yr        = 1'b1;
      end else begin
        nxt_o.month = inc_mon[4:0];
      end
    end
    if (c_yr) nxt_o.year = (cur_i.year == 8'h99) ? 8'h00 : inc_year;
  end

endmodule

// File: rtl/cal_bus_write.sv
module cal_bus_write
  import bcd_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  cal_time_t            base_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [7:0]           wdata_i,
  output cal_time_t            upd_o,
  output logic [NUM_FLD-1:0]   hit_o
);

  always_comb begin
    upd_o = base_i;
    hit_o = '0;
    if (we_i) begin
      case (addr_i)
        ADDR_W'(OFS_HUND): begin upd_o.hund  = wdata_i;      hit_o[FLD_HUND] = 1'b1; end
        ADDR_W'(OFS_SEC):  begin upd_o.sec   = wdata_i[6:0]; hit_o[FLD_SEC]  = 1'b1; end
        ADDR_W'(OFS_MIN):  begin upd_o.min   = wdata_i[6:0]; hit_o[FLD_MIN]  = 1'b1; end
        ADDR_W'(OFS_HOUR): begin upd_o.hour  = wdata_i[6:0]; hit_o[FLD_HOUR] = 1'b1; end
        ADDR_W'(OFS_DOW):  begin upd_o.dow   = wdata_i[2:0]; hit_o[FLD_DOW]  = 1'b1; end
        ADDR_W'(OFS_DATE): begin upd_o.date  = wdata_i[5:0]; hit_o[FLD_DATE] = 1'b1; end
        ADDR_W'(OFS_MON):  begin upd_o.month = wdata_i[4:0]; hit_o[FLD_MON]  = 1'b1; end
        ADDR_W'(OFS_YEAR): begin upd_o.year  = wdata_i;      hit_o[FLD_YEAR] = 1'b1; end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cal_read_mux.sv
module cal_read_mux
  import bcd_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  cal_time_t          vis_i,
  input  logic               osc_off_i,
  input  logic               sqw_off_i,
  input  logic               xfer_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [7:0]         rdata_o
);

  always_comb begin
    case (addr_i)
      ADDR_W'(OFS_HUND): rdata_o = vis_i.hund;
      ADDR_W'(OFS_SEC):  rdata_o = {1'b0, vis_i.sec};
      ADDR_W'(OFS_MIN):  rdata_o = {1'b0, vis_i.min};
      ADDR_W'(OFS_HOUR): rdata_o = {1'b0, vis_i.hour};
      ADDR_W'(OFS_DOW):  rdata_o = {5'b0, vis_i.dow};
      ADDR_W'(OFS_DATE): rdata_o = {2'b0, vis_i.date};
      ADDR_W'(OFS_MON):  rdata_o = {osc_off_i, sqw_off_i, 1'b0, vis_i.month};
      ADDR_W'(OFS_YEAR): rdata_o = vis_i.year;
      ADDR_W'(OFS_CMD):  rdata_o = {xfer_en_i, 7'b0};
      default:           rdata_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
  import bcd_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              sq_ref_i,
  output logic              sqw_o,
  output logic              sqw_oe_o
);

  cal_time_t          int_q, vis_q, adv_time, int_wr, vis_wr, merged, nxt_int, nxt_vis;
  logic [NUM_FLD-1:0] dirty_q, dirty_d, hit_int, hit_vis;
  logic               te_q, osc_off_q, sqw_off_q;
  logic               tick_adv, cmd_wr, mon_wr, load_en;

  assign tick_adv = tick_i && !osc_off_q;
  assign cmd_wr   = we_i && (addr_i == ADDR_W'(OFS_CMD));
  assign mon_wr   = we_i && (addr_i == ADDR_W'(OFS_MON));
  assign load_en  = cmd_wr && wdata_i[7] && !te_q;

  cal_advance i_adv (.cur_i(int_q), .nxt_o(adv_time));

  cal_bus_write #(.ADDR_W(ADDR_W)) i_wr_int (
    .base_i(tick_adv ? adv_time : int_q), .we_i(we_i && te_q), .addr_i(addr_i),
    .wdata_i(wdata_i), .upd_o(int_wr), .hit_o(hit_int));

  cal_bus_write #(.ADDR_W(ADDR_W)) i_wr_vis (
    .base_i(vis_q), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .upd_o(vis_wr), .hit_o(hit_vis));

  // fields written during freeze replace the running copy on re-enable
  always_comb begin
    merged = int_q;
    if (dirty_q[FLD_HUND]) merged.hund  = vis_q.hund;
    if (dirty_q[FLD_SEC])  merged.sec   = vis_q.sec;
    if (dirty_q[FLD_MIN])  merged.min   = vis_q.min;
    if (dirty_q[FLD_HOUR]) merged.hour  = vis_q.hour;
    if (dirty_q[FLD_DOW])  merged.dow   = vis_q.dow;
    if (dirty_q[FLD_DATE]) merged.date  = vis_q.date;
    if (dirty_q[FLD_MON])  merged.month = vis_q.month;
    if (dirty_q[FLD_YEAR]) merged.year  = vis_q.year;
  end

  always_comb begin
    dirty_d = dirty_q;
    if (load_en) begin
      nxt_int = merged;
      nxt_vis = merged;
      dirty_d = '0;
    end else begin
      nxt_int = int_wr;
      nxt_vis = te_q ? int_wr : vis_wr;
      if (!te_q) dirty_d = dirty_q | hit_vis;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q     <= CAL_RST;
      vis_q     <= CAL_RST;
      dirty_q   <= '0;
      te_q      <= 1'b1;
      osc_off_q <= 1'b0;
      sqw_off_q <= 1'b1;
    end else begin
      int_q   <= nxt_int;
      vis_q   <= nxt_vis;
      dirty_q <= dirty_d;
      if (cmd_wr) te_q <= wdata_i[7];
      if (mon_wr) {osc_off_q, sqw_off_q} <= wdata_i[7:6];
    end
  end

  cal_read_mux #(.ADDR_W(ADDR_W)) i_rd (
    .vis_i(vis_q), .osc_off_i(osc_off_q), .sqw_off_i(sqw_off_q), .xfer_en_i(te_q),
    .addr_i(addr_i), .rdata_o(rdata_o));

  assign sqw_oe_o = !sqw_off_q;
  assign sqw_o    = sq_ref_i && !sqw_off_q;

  assert_sec_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_adv && !we_i && int_q.hund == 8'h99) |=>
      (int_q.hund == 8'h00 && int_q.sec != $past(int_q.sec)));

  assert_track_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_q && !we_i) |=> (vis_q == int_q));

  assert_frozen_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!te_q && !we_i) |=> $stable(vis_q));

  assert_osc_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_off_q && !we_i) |=> $stable(int_q));

  assert_unused_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_SEC) || addr_i == ADDR_W'(OFS_HOUR)) |-> !rdata_o[7]);

endmodule

// File: tb/test_bcd_cal_clock.sv
module test_bcd_cal_clock;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sq_ref = 1'b0;
  logic       sqw, sqw_oe;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bcd_cal_clock #(.ADDR_W(4)) i_bcd_cal_clock (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sq_ref_i(sq_ref), .sqw_o(sqw), .sqw_oe_o(sqw_oe));

  // {hour, dow, date, month, year} before one tick, then expected after it
  localparam int NV = 16;
  localparam logic [79:0] VECS [NV] = '{
    {40'h23_07_31_01_23, 40'h00_01_01_02_23},
    {40'h23_03_30_04_23, 40'h00_04_01_05_23},
    {40'h23_02_28_02_23, 40'h00_03_01_03_23},
    {40'h23_02_28_02_24, 40'h00_03_29_02_24},
    {40'h23_05_29_02_00, 40'h00_06_01_03_00},
    {40'h23_06_31_12_99, 40'h00_07_01_01_00},
    {40'h09_01_15_06_10, 40'h10_01_15_06_10},
    {40'h19_01_15_06_10, 40'h20_01_15_06_10},
    {40'h51_04_10_07_05, 40'h72_04_10_07_05},
    {40'h72_04_10_07_05, 40'h61_04_10_07_05},
    {40'h71_04_10_07_05, 40'h52_05_11_07_05},
    {40'h52_04_10_07_05, 40'h41_04_10_07_05},
    {40'h49_04_10_07_05, 40'h50_04_10_07_05},
    {40'h23_01_30_08_23, 40'h00_02_31_08_23},
    {40'h23_01_29_02_96, 40'h00_02_01_03_96},
    {40'h23_03_30_11_22, 40'h00_04_01_12_22}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #2;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, h0, s0, m0;
    do_reset();

    // R1 reset values
    rd(4'h0, v); chk("R1 hund", v, 8'h00);
    rd(4'h1, v); chk("R1 sec", v, 8'h00);
    rd(4'h4, v); chk("R1 hour", v, 8'h00);
    rd(4'h6, v); chk("R1 dow", v, 8'h01);
    rd(4'h8, v); chk("R1 date", v, 8'h01);
    rd(4'h9, v); chk("R1 month", v, 8'h41);
    rd(4'hA, v); chk("R1 year", v, 8'h00);
    rd(4'hB, v); chk("R1 cmd", v, 8'h80);
    chk("R1 sqw_oe", {7'b0, sqw_oe}, 8'h00);

    // R2 R3 counting visible with transfer enabled
    ticks(5);
    rd(4'h0, v); chk("R2 R3 hund after 5 ticks", v, 8'h05);

    // R12 write with transfer enabled, then tens carry R2
    wr(4'h0, 8'h09);
    rd(4'h0, v); chk("R12 hund written", v, 8'h09);
    ticks(1);
    rd(4'h0, v); chk("R12 R2 hund tens carry", v, 8'h10);

    // R4 freeze
    do_reset();
    wr(4'hB, 8'h00);
    ticks(150);
    rd(4'h0, v); chk("R4 frozen hund", v, 8'h00);
    rd(4'h1, v); chk("R4 frozen sec", v, 8'h00);
    rd(4'hB, v); chk("R4 cmd frozen", v, 8'h00);
    wr(4'hB, 8'h80);
    rd(4'h0, v); chk("R4 resume hund", v, 8'h50);
    rd(4'h1, v); chk("R4 resume sec", v, 8'h01);

    // R5 write while frozen
    do_reset();
    wr(4'hB, 8'h00);
    ticks(10);
    wr(4'h2, 8'h42);
    rd(4'h2, v); chk("R5 frozen min readback", v, 8'h42);
    rd(4'h0, v); chk("R5 frozen hund held", v, 8'h00);
    wr(4'hB, 8'h80);
    rd(4'h2, v); chk("R5 min loaded", v, 8'h42);
    rd(4'h0, v); chk("R5 hund kept running", v, 8'h10);
    wr(4'hB, 8'h00);
    wr(4'h0, 8'h95);
    wr(4'hB, 8'h80);
    ticks(5);
    rd(4'h0, v); chk("R5 hund restart from written", v, 8'h00);
    rd(4'h1, v); chk("R5 R2 sec carry", v, 8'h01);
    rd(4'h2, v); chk("R5 min unchanged", v, 8'h42);

    // R2 minute and hour carry
    wr(4'hB, 8'h00);
    wr(4'h0, 8'h99); wr(4'h1, 8'h59); wr(4'h2, 8'h59); wr(4'h4, 8'h05);
    wr(4'hB, 8'h80);
    ticks(1);
    rd(4'h2, v); chk("R2 min wrap", v, 8'h00);
    rd(4'h4, v); chk("R2 hour carry", v, 8'h06);

    // R6 R7 R8 R9 rollover vectors
    for (int k = 0; k < NV; k++) begin
      wr(4'hB, 8'h00);
      wr(4'h0, 8'h99); wr(4'h1, 8'h59); wr(4'h2, 8'h59);
      wr(4'h4, VECS[k][79:72]); wr(4'h6, VECS[k][71:64]);
      wr(4'h8, VECS[k][63:56]); wr(4'h9, VECS[k][55:48] | 8'h40);
      wr(4'hA, VECS[k][47:40]);
      wr(4'hB, 8'h80);
      ticks(1);
      rd(4'h4, v); chk($sformatf("R6 R7 hour vec %0d", k), v, VECS[k][39:32]);
      rd(4'h6, v); chk($sformatf("R9 dow vec %0d", k), v, VECS[k][31:24]);
      rd(4'h8, v); chk($sformatf("R8 date vec %0d", k), v, VECS[k][23:16]);
      rd(4'h9, v); chk($sformatf("R8 month vec %0d", k), v, VECS[k][15:8] | 8'h40);
      rd(4'hA, v); chk($sformatf("R8 year vec %0d", k), v, VECS[k][7:0]);
      rd(4'h0, h0); rd(4'h1, s0); rd(4'h2, m0);
      chk($sformatf("R2 low fields vec %0d", k), h0 | s0 | m0, 8'h00);
    end

    // R10 oscillator stop and square wave
    do_reset();
    sq_ref = 1'b1;
    wr(4'h9, 8'h01);
    #2;
    chk("R10 sqw_oe on", {7'b0, sqw_oe}, 8'h01);
    chk("R10 sqw follows ref high", {7'b0, sqw}, 8'h01);
    sq_ref = 1'b0;
    #2;
    chk("R10 sqw follows ref low", {7'b0, sqw}, 8'h00);
    sq_ref = 1'b1;
    ticks(3);
    wr(4'h9, 8'h81);
    ticks(20);
    rd(4'h0, v); chk("R10 osc stopped hund", v, 8'h03);
    rd(4'h9, v); chk("R10 month ctrl read", v, 8'h81);
    wr(4'h9, 8'h41);
    #2;
    chk("R10 sqw_oe off", {7'b0, sqw_oe}, 8'h00);
    chk("R10 sqw low when off", {7'b0, sqw}, 8'h00);
    ticks(2);
    rd(4'h0, v); chk("R10 osc running again", v, 8'h05);

    // R11 unused bits and empty offsets
    do_reset();
    wr(4'h1, 8'hFF); rd(4'h1, v); chk("R11 sec bit7", v, 8'h7F);
    wr(4'h6, 8'hFF); rd(4'h6, v); chk("R11 dow high bits", v, 8'h07);
    wr(4'h8, 8'hFF); rd(4'h8, v); chk("R11 date high bits", v, 8'h3F);
    wr(4'h3, 8'hFF); rd(4'h3, v); chk("R11 offset 3", v, 8'h00);
    wr(4'hC, 8'hFF); rd(4'hC, v); chk("R11 offset C", v, 8'h00);
    wr(4'hB, 8'hFF); rd(4'hB, v); chk("R11 cmd low bits", v, 8'h80);
    wr(4'h9, 8'h7F); rd(4'h9, v); chk("R11 month bit5", v, 8'h5F);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule